// File: doc/BRIEF.md
# Multi-Strand Run Controller

This block keeps the run state of a group of four hardware strands. After reset only strand 0 runs, and it receives one power-on reset pulse as soon as reset is released. The other strands stay idle until an inter-processor interrupt (IPI) request starts them.

Each IPI request carries a type, a target strand id and a vector. The block turns an accepted request into one of four actions: a vectored interrupt post, a power-on reset, a halt, or a resume. Requests that are malformed raise an error pulse and change nothing. Requests aimed at a strand that does not exist are dropped without any effect.

Each strand also has a status register. A strand can write its own status register to put itself to sleep. A read of the register returns the strand's own id and the packed state codes of every strand in the group. The status port is selected by strand id. Reads are combinational and writes take effect at the next clock edge.

Top module: `strand_runctl`

## Requirements
- R1: Reset leaves strand 0 running and strands 1 to 3 idle. In the cycle right after reset is released, `ipi_ready` is low. The cycle after that, `por_pulse` is high for exactly one cycle with `por_strand` = 0, and `ipi_ready` becomes high.
- R2: An accepted request with type 0 and a legal target gives a one-cycle `post_pulse` in the next cycle, carrying the target id and the vector. If the target was idle, it becomes running.
- R3: An accepted type 1 request whose vector equals the power-on vector (default 1) gives a one-cycle `por_pulse` carrying the target id in the next cycle. The target becomes running.
- R4: A type 1 request with any other vector raises `ipi_err` for one cycle. It produces no reset pulse and leaves the run state unchanged.
- R5: Type 2 halts the target. A halted strand stays halted when an interrupt is posted to it, although the post pulse is still emitted.
- R6: Type 3 makes the target running, whatever its previous state.
- R7: Types 4 to 7 raise `ipi_err` for one cycle. They change no strand state and produce no post or reset pulse.
- R8: A request whose target id is 4 or more is ignored. It produces no pulse, no error and no state change.
- R9: A status write with the speculative bit clear stores the active bit. If the active bit is 0, the selected strand becomes idle. If it is 1, the run state is unchanged.
- R10: A status write with the speculative bit set raises `sts_err` in the next cycle. It stores nothing and changes no state.
- R11: The status read word has the stored active bit at bit 0 and a 0 at bit 2. Bits 9:8 hold the selected strand id. There is one 5-bit state code per strand, placed at bits 35:31 for strand 0, 30:26 for strand 1, 25:21 for strand 2 and 20:16 for strand 3. The codes are run = 0x05, idle = 0x00 and halt = 0x02. All other bits are 0.
- R12: When a status write and an IPI request target the same strand in the same cycle, the IPI action decides the strand's resulting run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ipi_valid | input | 1 | IPI request present |
| ipi_ready | output | 1 | IPI request can be accepted this cycle |
| ipi_type | input | 3 | 0 interrupt, 1 reset, 2 halt, 3 resume, 4-7 illegal |
| ipi_target | input | TGT_W | Target strand id |
| ipi_vector | input | VEC_W | Interrupt or reset vector |
| post_pulse | output | 1 | One-cycle interrupt post |
| post_strand | output | ID_W | Strand receiving the post |
| post_vector | output | VEC_W | Vector of the post |
| por_pulse | output | 1 | One-cycle power-on reset |
| por_strand | output | ID_W | Strand being reset |
| ipi_err | output | 1 | One-cycle illegal-request flag |
| sts_sel | input | ID_W | Strand whose status register is accessed |
| sts_we | input | 1 | Status register write |
| sts_wr_act | input | 1 | Write data, active bit |
| sts_wr_spec | input | 1 | Write data, speculative-enable bit |
| sts_rdata | output | 64 | Status read word for `sts_sel` |
| sts_err | output | 1 | One-cycle unsupported-write flag |
| run_en | output | N_STRANDS | Per-strand running indication |

## Verification
The bench targets four corner cases. First, a post to a halted strand: a design that treats halt like sleep would wrongly restart the strand. Second, reset requests carrying a non-power-on vector: a lax decoder would reset the strand anyway. Third, targets beyond the group: a design that truncates the id before checking it would hit a real strand. Fourth, a status write with the speculative bit set and the active bit clear: a design that skips the check would put the strand to sleep. The bench also issues a status write and an IPI to the same strand in the same cycle to pin down which one wins. It compares full status words so that a misplaced state field or id field shows up in the data.

// File: rtl/strand_runctl.sv
module strand_runctl #(
  parameter int N_STRANDS = 4,
  parameter int TGT_W     = 3,
  parameter int VEC_W     = 6,
  parameter int POR_VEC   = 1,
  localparam int ID_W     = $clog2(N_STRANDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ipi_valid,
  output logic                 ipi_ready,
  input  logic [2:0]           ipi_type,
  input  logic [TGT_W-1:0]     ipi_target,
  input  logic [VEC_W-1:0]     ipi_vector,
  output logic                 post_pulse,
  output logic [ID_W-1:0]      post_strand,
  output logic [VEC_W-1:0]     post_vector,
  output logic                 por_pulse,
  output logic [ID_W-1:0]      por_strand,
  output logic                 ipi_err,
  input  logic [ID_W-1:0]      sts_sel,
  input  logic                 sts_we,
  input  logic                 sts_wr_act,
  input  logic                 sts_wr_spec,
  output logic [63:0]          sts_rdata,
  output logic                 sts_err,
  output logic [N_STRANDS-1:0] run_en
);

  localparam logic [TGT_W:0]   NS_T  = (TGT_W+1)'(N_STRANDS);
  localparam logic [VEC_W-1:0] POR_V = VEC_W'(POR_VEC);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} st_e;

  st_e                 st_q [N_STRANDS];
  logic [N_STRANDS-1:0] act_q;
  logic                boot_q;

  assign ipi_ready = !boot_q;

  wire             acc    = ipi_valid && ipi_ready;
  wire             tgt_ok = {1'b0, ipi_target} < NS_T;
  wire [ID_W-1:0]  tid    = ipi_target[ID_W-1:0];
  wire             legal  = acc && tgt_ok;
  wire             por_ok = ipi_vector == POR_V;
  wire             do_post = legal && ipi_type == 3'd0;
  wire             do_rst  = legal && ipi_type == 3'd1 && por_ok;
  wire             do_halt = legal && ipi_type == 3'd2;
  wire             do_res  = legal && ipi_type == 3'd3;
  wire             bad     = legal && (ipi_type > 3'd3 || (ipi_type == 3'd1 && !por_ok));
  wire             wr_ok   = sts_we && !sts_wr_spec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q      <= 1'b1;
      act_q       <= N_STRANDS'(1);
      post_pulse  <= 1'b0;
      post_strand <= '0;
      post_vector <= '0;
      por_pulse   <= 1'b0;
      por_strand  <= '0;
      ipi_err     <= 1'b0;
      sts_err     <= 1'b0;
      for (int i = 0; i < N_STRANDS; i++)
        st_q[i] <= (i == 0) ? ST_RUN : ST_IDLE;
    end else begin
      boot_q     <= 1'b0;
      post_pulse <= do_post;
      por_pulse  <= boot_q || do_rst;
      ipi_err    <= bad;
      sts_err    <= sts_we && sts_wr_spec;
      if (do_post) begin
        post_strand <= tid;
        post_vector <= ipi_vector;
      end
      if (boot_q)      por_strand <= '0;
      else if (do_rst) por_strand <= tid;

      if (wr_ok) begin
        act_q[sts_sel] <= sts_wr_act;
        if (!sts_wr_act) st_q[sts_sel] <= ST_IDLE;
      end
      if (do_post && st_q[tid] != ST_HALT) st_q[tid] <= ST_RUN;
      if (do_rst || do_res)                st_q[tid] <= ST_RUN;
      if (do_halt)                         st_q[tid] <= ST_HALT;
    end
  end

  function automatic logic [4:0] code_of(st_e s);
    case (s)
      ST_RUN:  return 5'h05;
      ST_HALT: return 5'h02;
      default: return 5'h00;
    endcase
  endfunction

  always_comb begin
    sts_rdata = '0;
    sts_rdata[0] = act_q[sts_sel];
    sts_rdata[ID_W+7:8] = sts_sel;
    for (int i = 0; i < N_STRANDS; i++) begin
      sts_rdata = sts_rdata | (64'(code_of(st_q[i])) << (31 - 5*i));
      run_en[i] = st_q[i] == ST_RUN;
    end
  end

endmodule

// File: rtl/strand_runctl_chk.sv
module strand_runctl_chk #(
  parameter int N_STRANDS = 4,
  parameter int TGT_W     = 3,
  parameter int VEC_W     = 6,
  parameter int POR_VEC   = 1,
  localparam int ID_W     = $clog2(N_STRANDS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ipi_valid,
  input logic                 ipi_ready,
  input logic [2:0]           ipi_type,
  input logic [TGT_W-1:0]     ipi_target,
  input logic [VEC_W-1:0]     ipi_vector,
  input logic                 post_pulse,
  input logic                 por_pulse,
  input logic [ID_W-1:0]      por_strand,
  input logic                 ipi_err,
  input logic                 sts_we,
  input logic                 sts_wr_spec,
  input logic                 sts_err,
  input logic [N_STRANDS-1:0] run_en
);
  localparam logic [TGT_W:0] NS_T = (TGT_W+1)'(N_STRANDS);
  wire acc    = ipi_valid && ipi_ready;
  wire tgt_ok = {1'b0, ipi_target} < NS_T;

  p_post_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    post_pulse |-> $past(acc && tgt_ok && ipi_type == 3'd0));

  p_por_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (por_pulse && por_strand != '0) |->
      $past(acc && ipi_type == 3'd1 && ipi_vector == VEC_W'(POR_VEC)));

  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tgt_ok && ipi_type == 3'd2) |=> !run_en[$past(ipi_target[ID_W-1:0])]);

  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tgt_ok && ipi_type == 3'd3) |=> run_en[$past(ipi_target[ID_W-1:0])]);

  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tgt_ok && ipi_type > 3'd3) |=> ipi_err && !post_pulse);

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !tgt_ok) |=> !post_pulse && !por_pulse && !ipi_err);

  p_spec_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_err |-> $past(sts_we && sts_wr_spec));
endmodule

bind strand_runctl strand_runctl_chk #(
  .N_STRANDS(N_STRANDS), .TGT_W(TGT_W), .VEC_W(VEC_W), .POR_VEC(POR_VEC)
) u_chk (.*);

// File: tb/strand_runctl_bench.sv
module strand_runctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ipi_valid = 1'b0;
  logic ipi_ready;
  logic [2:0] ipi_type = '0;
  logic [2:0] ipi_target = '0;
  logic [5:0] ipi_vector = '0;
  logic post_pulse, por_pulse, ipi_err, sts_err;
  logic [1:0] post_strand, por_strand;
  logic [5:0] post_vector;
  logic [1:0] sts_sel = '0;
  logic sts_we = 1'b0, sts_wr_act = 1'b0, sts_wr_spec = 1'b0;
  logic [63:0] sts_rdata;
  logic [3:0] run_en;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strand_runctl u_strand_runctl (.*);

  // type, target, vector, exp post, exp por, exp err, exp run_en
  localparam logic [18:0] TBL [NV] = '{
    {3'd0, 3'd1, 6'd5, 1'b1, 1'b0, 1'b0, 4'b0011},  // R2 wake idle
    {3'd2, 3'd1, 6'd0, 1'b0, 1'b0, 1'b0, 4'b0001},  // R5 halt
    {3'd0, 3'd1, 6'd7, 1'b1, 1'b0, 1'b0, 4'b0001},  // R5 post no wake
    {3'd3, 3'd1, 6'd0, 1'b0, 1'b0, 1'b0, 4'b0011},  // R6 resume
    {3'd1, 3'd2, 6'd1, 1'b0, 1'b1, 1'b0, 4'b0111},  // R3 reset
    {3'd1, 3'd3, 6'd4, 1'b0, 1'b0, 1'b1, 4'b0111},  // R4 bad vector
    {3'd5, 3'd3, 6'd0, 1'b0, 1'b0, 1'b1, 4'b0111},  // R7 bad type
    {3'd0, 3'd4, 6'd3, 1'b0, 1'b0, 1'b0, 4'b0111},  // R8 out of range
    {3'd2, 3'd6, 6'd0, 1'b0, 1'b0, 1'b0, 4'b0111},  // R8 out of range
    {3'd2, 3'd0, 6'd0, 1'b0, 1'b0, 1'b0, 4'b0110},  // R5 halt strand 0
    {3'd7, 3'd2, 6'd0, 1'b0, 1'b0, 1'b1, 4'b0110},  // R7 bad type
    {3'd1, 3'd0, 6'd1, 1'b0, 1'b1, 1'b0, 4'b0111}   // R3 reset strand 0
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ipi(logic [2:0] t, logic [2:0] g, logic [5:0] v);
    ipi_valid = 1'b1; ipi_type = t; ipi_target = g; ipi_vector = v;
  endtask

  task automatic swr(logic [1:0] s, logic a, logic sp);
    sts_we = 1'b1; sts_sel = s; sts_wr_act = a; sts_wr_spec = sp;
  endtask

  task automatic step();
    @(negedge clk);
    ipi_valid = 1'b0; sts_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 boot
    chk("R1 ready low in boot", 64'(ipi_ready), 64'd0);
    chk("R1 run after reset", 64'(run_en), 64'b0001);
    chk("R11 reset read s0", sts_rdata, 64'h0000_0002_8000_0001);
    step();
    chk("R1 boot por", {62'd0, por_pulse, ipi_ready}, 64'b11);
    chk("R1 boot por strand", 64'(por_strand), 64'd0);
    step();
    chk("R1 por single", 64'(por_pulse), 64'd0);

    for (int i = 0; i < NV; i++) begin
      ipi(TBL[i][18:16], TBL[i][15:13], TBL[i][12:7]);
      step();
      chk($sformatf("R2/R3 pulses entry %0d", i),
          {61'd0, post_pulse, por_pulse, ipi_err}, 64'(TBL[i][6:4]));
      chk($sformatf("R5/R6 run_en entry %0d", i), 64'(run_en), 64'(TBL[i][3:0]));
      if (TBL[i][6])
        chk($sformatf("R2 post fields entry %0d", i),
            {56'd0, post_strand, post_vector}, {56'd0, TBL[i][14:13], TBL[i][12:7]});
      if (TBL[i][5])
        chk($sformatf("R3 por strand entry %0d", i), 64'(por_strand), 64'(TBL[i][14:13]));
      step();
      chk($sformatf("R2 single cycle entry %0d", i),
          {61'd0, post_pulse, por_pulse, ipi_err}, 64'd0);
    end

    sts_sel = 2'd1; #1;
    chk("R11 read s1", sts_rdata, 64'h0000_0002_94A0_0100);

    ipi(3'd2, 3'd2, 6'd0); step();
    sts_sel = 2'd2; #1;
    chk("R11 halt code s2", sts_rdata, 64'h0000_0002_9440_0200);

    ipi(3'd3, 3'd2, 6'd0); swr(2'd2, 1'b0, 1'b0); step();
    chk("R12 resume beats sleep", 64'(run_en), 64'b0111);

    swr(2'd1, 1'b0, 1'b0); step();
    chk("R9 sleep write", 64'(run_en), 64'b0101);
    sts_sel = 2'd1; #1;
    chk("R9 read after sleep", sts_rdata, 64'h0000_0002_80A0_0100);

    swr(2'd1, 1'b1, 1'b0); step();
    chk("R9 active write no wake", 64'(run_en), 64'b0101);
    sts_sel = 2'd1; #1;
    chk("R9 active bit stored", sts_rdata, 64'h0000_0002_80A0_0101);

    swr(2'd0, 1'b0, 1'b1); step();
    chk("R10 spec err", 64'(sts_err), 64'd1);
    chk("R10 no state change", 64'(run_en), 64'b0101);
    sts_sel = 2'd0; #1;
    chk("R10 nothing stored", sts_rdata, 64'h0000_0002_80A0_0001);
    step();
    chk("R10 err single", 64'(sts_err), 64'd0);

    ipi(3'd0, 3'd0, 6'd9); swr(2'd0, 1'b0, 1'b0); step();
    chk("R12 post beats sleep", 64'(run_en), 64'b0101);
    chk("R12 post fields", {56'd0, post_pulse, post_strand, post_vector},
        {56'd0, 1'b1, 2'd0, 6'd9});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule